// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block receives configuration writes over a three-wire serial link (serial clock, serial data, active-low load strobe) and keeps a bank of 256 registers, each 24 bits wide. A transfer opens with the strobe going low. It carries an 8-bit register address and then one or more 24-bit data words. Every field is sent least significant bit first. Each extra word in the same transfer goes to the next address up.

Each received word goes into a shadow copy and is marked pending. It becomes visible in the active copy later, at one of two commit points chosen per register by a parameter mask. Registers outside the mask commit when the load strobe rises. Registers inside the mask commit on a chosen falling edge of horizontal sync, counted from the most recent falling edge of vertical sync. The chosen edge index is held in an update register that lives in the bank itself, so a video front end can retime a whole frame's settings to one line.

All five pins are synchronized into the system clock domain. The system clock must run at least four times faster than the serial clock. The active copy is read through a combinational address/data port.

Top module: `cfg_serial_port`

## Requirements
- R1: A write of an 8-bit address followed by exactly 24 data bits, both least significant bit first and sampled on serial clock rising edges while the strobe is low, stores the data at that address.
- R2: For a register whose mask bit is 0 (default: addresses 0 to 127), the active value does not change while the strobe is still low and takes the new value once the strobe has risen.
- R3: While the strobe stays low, each further complete 24-bit word is stored at the address one above the previous word.
- R4: Auto-increment wraps from address 255 to address 0.
- R5: A final word with fewer than 24 bits when the strobe rises changes no register. Complete words earlier in the same transfer are still stored.
- R6: For a register whose mask bit is 1 (default: addresses 128 to 255), a strobe rise does not change the active value.
- R7: Register 0 is the update register. With value N, the synchronized commit happens on falling edge N+1 of horizontal sync after a vertical-sync falling edge, so 0 selects the first one. Falling edges before that one leave the active values unchanged.
- R8: Horizontal-sync falling edges change no synchronized register unless a vertical-sync falling edge came first. Each vertical-sync falling edge allows exactly one commit.
- R9: Serial clock edges while the strobe is high are ignored and do not disturb the next transfer.
- R10: After reset every active register reads 0.
- R11: When a shadow register is written more than once before its commit, the last value written is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_din | input | 1 | Serial data, least significant bit first |
| ser_load_n | input | 1 | Active-low load strobe framing a transfer |
| hsync_n | input | 1 | Horizontal sync; falling edges are counted |
| vsync_n | input | 1 | Vertical sync; a falling edge arms the synchronized commit |
| rd_addr | input | 8 | Address of the active register to read |
| rd_data | output | 24 | Active value at rd_addr |

## Verification
The hardest case to reach is a synchronized commit with a non-zero update value. The update register must be loaded first, and that load has to arrive through address wrap-around in the same burst that writes a synchronized register. After that, a vertical-sync pulse and a train of horizontal-sync pulses are needed. The bench reads the affected registers after each horizontal pulse. This shows the values stay unchanged up to the selected line and change exactly on it. Truncated final words and serial clock activity while the strobe is high are driven as separate transfers, and the bench reads the registers that those transfers could have touched.

// File: rtl/cfgw_pkg.sv
// Package: shared widths and pin indices for the serial configuration loader.
// Assumes the protocol field widths are fixed: 8-bit address, 24-bit word.
package cfgw_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 24;
    localparam int NREG   = 1 << ADDR_W;
    localparam int PIN_N  = 5;
    // bit positions of the pins in the synchronizer vector
    localparam int P_SCLK = 0;
    localparam int P_SDI  = 1;
    localparam int P_LOAD = 2;
    localparam int P_HS   = 3;
    localparam int P_VS   = 4;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/cfgw_pinsync.sv
// Module: multi-bit level synchronizer.
// Each bit is an independent asynchronous pin; no coherence between bits is
// assumed. Reset value per bit is given by RST_VAL so idle-high pins do not
// produce false edges after reset.
module cfgw_pinsync #(
    parameter int               WIDTH   = 5,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Purpose: shift the pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgw_rx.sv
// Module: serial deserializer.
// Assembles an LSB-first address, then LSB-first 24-bit words, while the
// load strobe is low. Emits a one-cycle word strobe per complete word and
// advances the address (wrapping) after each. A partial word is dropped when
// the strobe rises because the counter is cleared. Assumes synchronized inputs
// and at least four system clocks per serial clock half period pair.
module cfgw_rx
    import cfgw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sclk,
    input  logic  sdi,
    input  logic  load_n,
    output logic  wr_vld,
    output addr_t wr_addr,
    output word_t wr_data,
    output logic  load_end
);
    localparam int CNT_W = $clog2(DATA_W);

    logic             sclk_d;
    logic             load_d;
    logic             in_addr;
    logic [CNT_W-1:0] cnt;
    logic             sclk_rise;

    assign sclk_rise = sclk && !sclk_d;
    assign load_end  = load_n && !load_d;

    // Purpose: edge history, bit counting, address and word shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            load_d  <= 1'b1;
            in_addr <= 1'b1;
            cnt     <= '0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_vld  <= 1'b0;
        end else begin
            sclk_d <= sclk;
            load_d <= load_n;
            wr_vld <= 1'b0;
            if (wr_vld) wr_addr <= wr_addr + 1'b1;
            if (load_n) begin
                in_addr <= 1'b1;
                cnt     <= '0;
            end else if (sclk_rise) begin
                if (in_addr) begin
                    wr_addr <= {sdi, wr_addr[ADDR_W-1:1]};
                    if (cnt == CNT_W'(ADDR_W - 1)) begin
                        in_addr <= 1'b0;
                        cnt     <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    wr_data <= {sdi, wr_data[DATA_W-1:1]};
                    if (cnt == CNT_W'(DATA_W - 1)) begin
                        wr_vld <= 1'b1;
                        cnt    <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    AST_WORD_ONLY_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |-> !load_n); // R9
    AST_ADDR_STEPS_UP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |=> wr_addr == addr_t'($past(wr_addr) + 1'b1)); // R3
endmodule

// File: rtl/cfgw_linesched.sv
// Module: line-synchronized commit scheduler.
// A vertical-sync falling edge arms it and clears the line count. Each later
// horizontal-sync falling edge either fires (count equals the update value)
// or increments the count. Firing disarms until the next vertical edge.
// A horizontal edge in the same cycle as a vertical edge is not counted.
module cfgw_linesched
    import cfgw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hs_n,
    input  logic  vs_n,
    input  word_t upd_line,
    output logic  fire
);
    logic  hs_d;
    logic  vs_d;
    logic  armed;
    word_t hcnt;
    logic  hs_fall;
    logic  vs_fall;

    assign hs_fall = !hs_n && hs_d;
    assign vs_fall = !vs_n && vs_d;
    assign fire    = armed && hs_fall && !vs_fall && (hcnt == upd_line);

    // Purpose: track sync edges, arm on vertical, count horizontal edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_d  <= 1'b1;
            vs_d  <= 1'b1;
            armed <= 1'b0;
            hcnt  <= '0;
        end else begin
            hs_d <= hs_n;
            vs_d <= vs_n;
            if (vs_fall) begin
                armed <= 1'b1;
                hcnt  <= '0;
            end else if (fire) begin
                armed <= 1'b0;
            end else if (armed && hs_fall) begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    AST_ONE_COMMIT_PER_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !armed); // R8
    AST_FIRE_NEEDS_HS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $fell(hs_n)); // R7
endmodule

// File: rtl/cfgw_bank.sv
// Module: shadow/active register bank.
// A word strobe loads the shadow copy and sets its pending flag. Pending
// registers outside SYNC_MASK copy to active on the strobe-rise pulse;
// pending registers inside SYNC_MASK copy on the line commit pulse.
// A write in the same cycle as a commit keeps the entry pending.
module cfgw_bank
    import cfgw_pkg::*;
#(
    parameter logic [NREG-1:0] SYNC_MASK = {{(NREG/2){1'b1}}, {(NREG/2){1'b0}}},
    parameter int              UPD_ADDR  = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_vld,
    input  addr_t wr_addr,
    input  word_t wr_data,
    input  logic  load_end,
    input  logic  line_fire,
    input  addr_t rd_addr,
    output word_t rd_data,
    output word_t upd_line
);
    logic [NREG-1:0]        pend;
    logic [NREG*DATA_W-1:0] actv;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        word_t shadow_q;
        word_t act_q;
        logic  pend_q;
        logic  take;
        logic  hit;

        assign take = pend_q && (SYNC_MASK[i] ? line_fire : load_end);
        assign hit  = wr_vld && (wr_addr == addr_t'(i));

        // Purpose: hold one shadow/active pair and its pending flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q <= '0;
                act_q    <= '0;
                pend_q   <= 1'b0;
            end else begin
                if (take) act_q <= shadow_q;
                if (hit) begin
                    shadow_q <= wr_data;
                    pend_q   <= 1'b1;
                end else if (take) begin
                    pend_q <= 1'b0;
                end
            end
        end

        assign pend[i]                   = pend_q;
        assign actv[i*DATA_W +: DATA_W] = act_q;
    end

    assign rd_data  = actv[rd_addr*DATA_W +: DATA_W];
    assign upd_line = actv[UPD_ADDR*DATA_W +: DATA_W];

    AST_ACTIVE_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_end && !line_fire) |=> $stable(actv)); // R2
    AST_WORD_MARKS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |=> pend[$past(wr_addr)]); // R5
endmodule

// File: rtl/cfg_serial_port.sv
// Module: serial configuration register loader (top).
// Synchronizes the five pins, deserializes writes, schedules line-locked
// commits and holds the shadow/active bank. Assumes the system clock runs at
// least four times the serial clock and that sync pulses last several
// system clocks.
module cfg_serial_port
    import cfgw_pkg::*;
#(
    parameter logic [NREG-1:0] SYNC_MASK   = {{(NREG/2){1'b1}}, {(NREG/2){1'b0}}},
    parameter int              UPD_ADDR    = 0,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_load_n,
    input  logic              hsync_n,
    input  logic              vsync_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [PIN_N-1:0] IDLE = PIN_N'((1 << P_LOAD) | (1 << P_HS) | (1 << P_VS));

    logic [PIN_N-1:0] pins_raw;
    logic [PIN_N-1:0] pins;
    logic             wr_vld;
    addr_t            wr_addr;
    word_t            wr_data;
    logic             load_end;
    logic             line_fire;
    word_t            upd_line;

    always_comb begin
        pins_raw         = '0;
        pins_raw[P_SCLK] = ser_clk;
        pins_raw[P_SDI]  = ser_din;
        pins_raw[P_LOAD] = ser_load_n;
        pins_raw[P_HS]   = hsync_n;
        pins_raw[P_VS]   = vsync_n;
    end

    cfgw_pinsync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins)
    );

    cfgw_rx u_rx (
        .clk(clk), .rst_n(rst_n),
        .sclk(pins[P_SCLK]), .sdi(pins[P_SDI]), .load_n(pins[P_LOAD]),
        .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data), .load_end(load_end)
    );

    cfgw_linesched u_sched (
        .clk(clk), .rst_n(rst_n),
        .hs_n(pins[P_HS]), .vs_n(pins[P_VS]),
        .upd_line(upd_line), .fire(line_fire)
    );

    cfgw_bank #(.SYNC_MASK(SYNC_MASK), .UPD_ADDR(UPD_ADDR)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_end(load_end), .line_fire(line_fire),
        .rd_addr(rd_addr), .rd_data(rd_data), .upd_line(upd_line)
    );

    AST_NO_WORD_AT_LOAD_END: assert property (@(posedge clk) disable iff (!rst_n)
        load_end |-> !wr_vld); // R5
endmodule

// File: tb/sim_cfg_serial_port.sv
// Bench: scoreboard of expected register values, drained by a monitor task.
module sim_cfg_serial_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic        ser_load_n = 1'b1;
    logic        hsync_n = 1'b1;
    logic        vsync_n = 1'b1;
    logic [7:0]  rd_addr = '0;
    logic [23:0] rd_data;

    int errs = 0;
    int checks = 0;

    typedef struct {
        logic [7:0]  a;
        logic [23:0] d;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    cfg_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_load_n(ser_load_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [23:0] d, input string req);
        exp_t e;
        e.a = a; e.d = d; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: pops expected entries and compares against the read port
    task automatic monitor();
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            @(negedge clk);
            rd_addr = e.a;
            #1;
            checks++;
            if (rd_data !== e.d) begin
                errs++;
                $display("FAIL %s addr=%02h actual=%06h expected=%06h", e.req, e.a, rd_data, e.d);
            end
        end
    endtask

    task automatic ser_bits(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            ser_din = v[i];
            ser_clk = 1'b0;
            waitc(4);
            ser_clk = 1'b1;
            waitc(4);
        end
        ser_clk = 1'b0;
        waitc(4);
    endtask

    task automatic open_load();
        ser_load_n = 1'b0;
        waitc(4);
    endtask

    task automatic close_load();
        ser_load_n = 1'b1;
        waitc(10);
    endtask

    task automatic hs_pulse();
        hsync_n = 1'b0; waitc(6);
        hsync_n = 1'b1; waitc(6);
    endtask

    task automatic vs_pulse();
        vsync_n = 1'b0; waitc(6);
        vsync_n = 1'b1; waitc(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        waitc(5);
        rst_n = 1'b1;
        waitc(5);

        // R10: reset state
        expect_reg(8'h05, 24'h0, "R10");
        expect_reg(8'h80, 24'h0, "R10");
        expect_reg(8'hFF, 24'h0, "R10");
        monitor();

        // R1/R2: single write to immediate register, held until strobe rise
        open_load();
        ser_bits(32'h05, 8);
        ser_bits(32'hABCDEF, 24);
        waitc(10);
        expect_reg(8'h05, 24'h0, "R2");
        monitor();
        close_load();
        expect_reg(8'h05, 24'hABCDEF, "R1");
        monitor();

        // R3/R6: burst crossing from immediate into synchronized registers
        open_load();
        ser_bits(32'h7E, 8);
        ser_bits(32'h111111, 24);
        ser_bits(32'h222222, 24);
        ser_bits(32'h333333, 24);
        close_load();
        expect_reg(8'h7E, 24'h111111, "R3");
        expect_reg(8'h7F, 24'h222222, "R3");
        expect_reg(8'h80, 24'h0, "R6");
        monitor();

        // R8: horizontal edge without vertical edge does not commit
        hs_pulse();
        expect_reg(8'h80, 24'h0, "R8");
        monitor();

        // R7: update value 0 selects the first horizontal edge
        vs_pulse();
        expect_reg(8'h80, 24'h0, "R7");
        monitor();
        hs_pulse();
        expect_reg(8'h80, 24'h333333, "R7");
        monitor();

        // R5: truncated single write
        open_load();
        ser_bits(32'h10, 8);
        ser_bits(32'h7FFFFF, 23);
        close_load();
        expect_reg(8'h10, 24'h0, "R5");
        monitor();

        // R5: burst ending with a partial word
        open_load();
        ser_bits(32'h20, 8);
        ser_bits(32'hAAAAAA, 24);
        ser_bits(32'hBBBBBB, 24);
        ser_bits(32'h3FF, 10);
        close_load();
        expect_reg(8'h20, 24'hAAAAAA, "R5");
        expect_reg(8'h21, 24'hBBBBBB, "R5");
        expect_reg(8'h22, 24'h0, "R5");
        monitor();

        // R4: wrap from 255 to 0; register 0 gets update value 2
        open_load();
        ser_bits(32'hFF, 8);
        ser_bits(32'h5A5A5A, 24);
        ser_bits(32'h000002, 24);
        close_load();
        expect_reg(8'h00, 24'h000002, "R4");
        expect_reg(8'hFF, 24'h0, "R6");
        monitor();

        // R11: two writes to the same synchronized register before commit
        open_load();
        ser_bits(32'h81, 8);
        ser_bits(32'h0000AA, 24);
        close_load();
        open_load();
        ser_bits(32'h81, 8);
        ser_bits(32'h0000BB, 24);
        close_load();

        // R7: update value 2 selects the third horizontal edge
        vs_pulse();
        hs_pulse();
        hs_pulse();
        expect_reg(8'hFF, 24'h0, "R7");
        expect_reg(8'h81, 24'h0, "R7");
        monitor();
        hs_pulse();
        expect_reg(8'hFF, 24'h5A5A5A, "R4");
        expect_reg(8'h81, 24'h0000BB, "R11");
        monitor();

        // R8: one commit per vertical edge
        open_load();
        ser_bits(32'h82, 8);
        ser_bits(32'hCCCCCC, 24);
        close_load();
        hs_pulse();
        hs_pulse();
        hs_pulse();
        hs_pulse();
        expect_reg(8'h82, 24'h0, "R8");
        monitor();

        // R9: serial activity with strobe high is ignored
        ser_bits(32'h123456_05, 32);
        waitc(10);
        expect_reg(8'h05, 24'hABCDEF, "R9");
        monitor();
        open_load();
        ser_bits(32'h06, 8);
        ser_bits(32'h654321, 24);
        close_load();
        expect_reg(8'h06, 24'h654321, "R9");
        expect_reg(8'h05, 24'hABCDEF, "R9");
        monitor();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule